// File: doc/BRIEF.md
# D-Channel Transmit Chunk Sequencer

This block feeds one outgoing D-channel frame, held in an external frame buffer, into a downstream HDLC controller whose transmit FIFO holds 32 bytes. It walks the frame in chunks of at most 32 bytes and writes one byte per cycle. After each chunk it issues a command to the controller. The command always has the transmit-fill bit set. It also carries the message-end bit when that chunk ends the frame. It then waits for the controller's pool-ready event before it sends more data. After the final chunk, the next pool-ready releases the frame and produces a one-cycle confirmation.

A new frame is taken only while the sequencer is idle, the link is active and the length is non-zero. Any other request is dropped. When the controller reports a transmit underrun or asks for the message to be repeated, the sequencer folds the bytes already sent back into the remaining count. The next pool-ready then resends the frame from byte 0. Bit stuffing and CRC generation are left to the controller.

The sequencer has five states:

- `S_IDLE` waits for a request.
- `S_FILL` writes one byte each cycle.
- `S_ISSUE` presents the command for one cycle.
- `S_WAIT` waits for pool-ready or an error.
- `S_CONFIRM` pulses the confirmation.

Its transitions are:

- IDLE→FILL on an accepted request.
- FILL→FILL on every byte except the last of a chunk.
- FILL→ISSUE on the last byte of a chunk.
- ISSUE→WAIT unconditionally.
- WAIT→WAIT on an underrun or repeat, which triggers the rewind.
- WAIT→FILL on pool-ready while bytes remain.
- WAIT→CONFIRM on pool-ready when no bytes remain.
- CONFIRM→IDLE unconditionally.

Top module: `dtx_chunk_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `fifo_wr`, `cmd_valid` and `confirm` are all low.
- R2: A request (`frame_req` high at a clock edge) is accepted only when the block is idle, `link_active` is high and `frame_len` is non-zero. Any other request is discarded: `busy` stays low and no byte is written.
- R3: The first chunk starts in the cycle right after acceptance, without waiting for pool-ready. Bytes are written one per cycle, in ascending buffer address from 0. `fifo_data` equals the buffer byte at `buf_addr`.
- R4: Each chunk holds the smaller of the remaining byte count and 32.
- R5: One cycle after the last byte of a chunk, `cmd_valid` pulses for one cycle. `cmd_bits` is 0x08 (transmit-fill) when bytes remain and 0x0A (transmit-fill 0x08 plus message-end 0x02) for the final chunk. The command never coincides with a byte write.
- R6: Pool-ready while waiting with bytes left starts the next chunk in the following cycle. That chunk continues at the next buffer address.
- R7: Pool-ready while waiting with no bytes left raises `confirm` for exactly one cycle in the following cycle. `busy` falls the cycle after that.
- R8: An underrun or message-repeat while waiting rewinds the frame. The next chunk starts again at address 0, and the full frame length is resent. The rewind takes priority over a pool-ready in the same cycle, which is then dropped.
- R9: Pool-ready, underrun and message-repeat while idle have no effect.
- R10: A request that arrives while a frame is in flight is refused. The frame in flight completes with its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_active | input | 1 | Layer-1 link is in the active state |
| frame_req | input | 1 | Request to send a frame (one cycle) |
| frame_len | input | LEN_W | Frame length in bytes |
| busy | output | 1 | A frame is in flight |
| buf_addr | output | LEN_W | Frame buffer read address |
| buf_data | input | 8 | Frame buffer byte at `buf_addr` |
| fifo_wr | output | 1 | Transmit FIFO write strobe |
| fifo_data | output | 8 | Transmit FIFO write byte |
| cmd_valid | output | 1 | Command strobe to the controller |
| cmd_bits | output | 8 | Command bits (fill 0x08, message-end 0x02) |
| pool_ready | input | 1 | Controller's transmit pool is ready for more |
| underrun | input | 1 | Controller reports transmit underrun |
| msg_repeat | input | 1 | Controller asks for the message to be repeated |
| confirm | output | 1 | Frame fully sent (one cycle) |

## Verification
Take a request accepted at edge k. The first write strobe is visible in the cycle after k. A chunk of n bytes takes n cycles, and the command appears in the cycle after its last byte. A pool-ready at an edge produces either a write or a `confirm` in the next cycle, and `busy` falls one cycle after `confirm`. The bench drives inputs on falling edges. It logs every write, command and confirmation at rising edges into ordered records, so each check compares byte addresses, byte values, chunk boundaries and command codes rather than absolute times. The immediate one-cycle results (the first write after acceptance, `confirm`, `busy` falling) are sampled at the falling edge where they are due.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_ISSUE,
        S_WAIT,
        S_CONFIRM
    } dtx_state_e;

    localparam logic [7:0] CMD_XMIT_RESET = 8'h01;
    localparam logic [7:0] CMD_MSG_END    = 8'h02;
    localparam logic [7:0] CMD_FILL       = 8'h08;
    localparam logic [7:0] CMD_RX_RESET   = 8'h40;
    localparam logic [7:0] CMD_RX_DONE    = 8'h80;
endpackage

// File: rtl/dtx_byte_ledger.sv
module dtx_byte_ledger #(
    parameter int LEN_W = 11,
    parameter int CHUNK = 32,
    localparam int CNT_W = $clog2(CHUNK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             start_chunk,
    input  logic             byte_step,
    input  logic             rewind,
    input  logic             clear,
    output logic [LEN_W-1:0] sent,
    output logic             last_in_chunk,
    output logic             none_left
);
    logic [LEN_W-1:0] remain;
    logic [CNT_W-1:0] chunk_left;

    function automatic logic [CNT_W-1:0] chunk_of(input logic [LEN_W-1:0] r);
        if (r > LEN_W'(CHUNK)) return CNT_W'(CHUNK);
        return CNT_W'(r);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain     <= '0;
            sent       <= '0;
            chunk_left <= '0;
        end else if (clear) begin
            remain     <= '0;
            sent       <= '0;
            chunk_left <= '0;
        end else if (load) begin
            remain     <= len;
            sent       <= '0;
            chunk_left <= chunk_of(len);
        end else if (rewind) begin
            remain     <= remain + sent;
            sent       <= '0;
        end else if (start_chunk) begin
            chunk_left <= chunk_of(remain);
        end else if (byte_step) begin
            remain     <= remain - 1'b1;
            sent       <= sent + 1'b1;
            chunk_left <= chunk_left - 1'b1;
        end
    end

    assign last_in_chunk = (chunk_left == CNT_W'(1));
    assign none_left     = (remain == '0);
endmodule

// File: rtl/dtx_seq_fsm.sv
module dtx_seq_fsm
    import dtx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_req,
    input  logic link_active,
    input  logic len_ok,
    input  logic pool_ready,
    input  logic underrun,
    input  logic msg_repeat,
    input  logic last_in_chunk,
    input  logic none_left,
    output logic load,
    output logic start_chunk,
    output logic byte_step,
    output logic rewind,
    output logic clear,
    output logic fifo_wr,
    output logic cmd_valid,
    output logic confirm,
    output logic busy
);
    dtx_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        load        = 1'b0;
        start_chunk = 1'b0;
        byte_step   = 1'b0;
        rewind      = 1'b0;
        clear       = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (frame_req && link_active && len_ok) begin
                    load     = 1'b1;
                    state_nx = S_FILL;
                end
            end
            S_FILL: begin
                byte_step = 1'b1;
                if (last_in_chunk) state_nx = S_ISSUE;
            end
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT: begin
                if (underrun || msg_repeat) begin
                    rewind = 1'b1;
                end else if (pool_ready) begin
                    if (!none_left) begin
                        start_chunk = 1'b1;
                        state_nx    = S_FILL;
                    end else begin
                        clear    = 1'b1;
                        state_nx = S_CONFIRM;
                    end
                end
            end
            S_CONFIRM: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        fifo_wr   = (state == S_FILL);
        cmd_valid = (state == S_ISSUE);
        confirm   = (state == S_CONFIRM);
        busy      = (state != S_IDLE);
    end
endmodule

// File: rtl/dtx_chunk_ctrl.sv
module dtx_chunk_ctrl
    import dtx_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CHUNK = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_active,
    input  logic             frame_req,
    input  logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic [LEN_W-1:0] buf_addr,
    input  logic [7:0]       buf_data,
    output logic             fifo_wr,
    output logic [7:0]       fifo_data,
    output logic             cmd_valid,
    output logic [7:0]       cmd_bits,
    input  logic             pool_ready,
    input  logic             underrun,
    input  logic             msg_repeat,
    output logic             confirm
);
    logic load, start_chunk, byte_step, rewind, clear;
    logic last_in_chunk, none_left;

    dtx_byte_ledger #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_ledger (
        .clk(clk), .rst_n(rst_n), .load(load), .len(frame_len),
        .start_chunk(start_chunk), .byte_step(byte_step), .rewind(rewind),
        .clear(clear), .sent(buf_addr), .last_in_chunk(last_in_chunk),
        .none_left(none_left)
    );

    dtx_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req),
        .link_active(link_active), .len_ok(frame_len != '0),
        .pool_ready(pool_ready), .underrun(underrun), .msg_repeat(msg_repeat),
        .last_in_chunk(last_in_chunk), .none_left(none_left),
        .load(load), .start_chunk(start_chunk), .byte_step(byte_step),
        .rewind(rewind), .clear(clear), .fifo_wr(fifo_wr),
        .cmd_valid(cmd_valid), .confirm(confirm), .busy(busy)
    );

    assign fifo_data = buf_data;
    assign cmd_bits  = cmd_valid ? (CMD_FILL | (none_left ? CMD_MSG_END : 8'h00)) : 8'h00;
endmodule

// File: rtl/dtx_chunk_ctrl_chk.sv
module dtx_chunk_ctrl_chk #(
    parameter int CHUNK = 32,
    localparam int RUN_W = $clog2(CHUNK + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic frame_req,
    input logic link_active,
    input logic busy,
    input logic fifo_wr,
    input logic cmd_valid,
    input logic confirm
);
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len <= '0;
        else if (fifo_wr) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    // R4
    chunk_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (run_len < RUN_W'(CHUNK)));

    // R5
    cmd_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(fifo_wr) && !fifo_wr));

    // R5
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    confirm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |=> (!busy && !confirm));

    // R2
    accept_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_req && link_active));

    // R3
    write_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> busy);
endmodule

bind dtx_chunk_ctrl dtx_chunk_ctrl_chk #(.CHUNK(CHUNK)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .link_active(link_active),
    .busy(busy), .fifo_wr(fifo_wr), .cmd_valid(cmd_valid), .confirm(confirm)
);

// File: tb/dtx_chunk_ctrl_bench.sv
module dtx_chunk_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 11;
    localparam int LOG_N = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_active = 1'b1;
    logic frame_req = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic busy;
    logic [LEN_W-1:0] buf_addr;
    logic [7:0] buf_data;
    logic fifo_wr;
    logic [7:0] fifo_data;
    logic cmd_valid;
    logic [7:0] cmd_bits;
    logic pool_ready = 1'b0;
    logic underrun = 1'b0;
    logic msg_repeat = 1'b0;
    logic confirm;

    int checks = 0;
    int errors = 0;
    int nwr = 0, ncmd = 0, nconf = 0;
    int log_addr [LOG_N];
    int log_data [LOG_N];
    int log_cmd  [32];
    int log_cpos [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bdat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    always_comb buf_data = bdat(int'(buf_addr));

    dtx_chunk_ctrl #(.LEN_W(LEN_W), .CHUNK(32)) u_dtx_chunk_ctrl (
        .clk(clk), .rst_n(rst_n), .link_active(link_active), .frame_req(frame_req),
        .frame_len(frame_len), .busy(busy), .buf_addr(buf_addr), .buf_data(buf_data),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .cmd_valid(cmd_valid),
        .cmd_bits(cmd_bits), .pool_ready(pool_ready), .underrun(underrun),
        .msg_repeat(msg_repeat), .confirm(confirm)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (fifo_wr && nwr < LOG_N) begin
                log_addr[nwr] = int'(buf_addr);
                log_data[nwr] = int'(fifo_data);
                nwr++;
            end
            if (cmd_valid && ncmd < 32) begin
                log_cmd[ncmd]  = int'(cmd_bits);
                log_cpos[ncmd] = nwr;
                ncmd++;
            end
            if (confirm) nconf++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_log();
        @(negedge clk);
        nwr = 0; ncmd = 0; nconf = 0;
    endtask

    task automatic start_frame(input int len);
        @(negedge clk);
        frame_len = LEN_W'(len);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
    endtask

    task automatic pulse_pool();
        @(negedge clk);
        pool_ready = 1'b1;
        @(negedge clk);
        pool_ready = 1'b0;
    endtask

    task automatic wait_cmds(input int n, input string tag);
        int t = 0;
        while (ncmd < n && t < 300) begin
            @(negedge clk);
            t++;
        end
        check({tag, " command count reached"}, ncmd, n);
    endtask

    task automatic check_bytes(input string tag, input int first, input int count, input int addr0);
        for (int i = 0; i < count; i++) begin
            check({tag, " byte address"}, log_addr[first+i], addr0 + i);
            check({tag, " byte value"}, log_data[first+i], int'(bdat(addr0 + i)));
        end
    endtask

    // Send a frame of len bytes with no errors; verifies chunks and commands.
    task automatic run_clean(input int len, input string tag);
        int nchunks = (len + 31) / 32;
        clear_log();
        start_frame(len);
        for (int c = 0; c < nchunks; c++) begin
            wait_cmds(c + 1, tag);
            check({tag, " R4 chunk end position"}, log_cpos[c], (c == nchunks-1) ? len : 32*(c+1));
            check({tag, " R5 command code"}, log_cmd[c], (c == nchunks-1) ? 8'h0A : 8'h08);
            pulse_pool();
            if (c == nchunks-1) begin
                check({tag, " R7 confirm pulse"}, int'(confirm), 1);
                @(negedge clk);
                check({tag, " R7 busy released"}, int'(busy), 0);
            end
        end
        check({tag, " R3 total bytes"}, nwr, len);
        check_bytes({tag, " R3"}, 0, len, 0);
        check({tag, " R7 single confirm"}, nconf, 1);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", int'(busy), 0);
        check("R1 fifo_wr after reset", int'(fifo_wr), 0);
        check("R1 cmd_valid after reset", int'(cmd_valid), 0);
        check("R1 confirm after reset", int'(confirm), 0);
    endtask

    task automatic t_first_chunk_now();
        clear_log();
        start_frame(5);
        check("R3 write in cycle after accept", int'(fifo_wr), 1);
        check("R3 first address", int'(buf_addr), 0);
        wait_cmds(1, "R3");
        repeat (3) @(negedge clk);
        check("R6 no further bytes before pool-ready", nwr, 5);
        pulse_pool();
        check("R7 confirm after final pool-ready", int'(confirm), 1);
        @(negedge clk);
        check("R7 busy low after confirm", int'(busy), 0);
    endtask

    task automatic t_discard();
        clear_log();
        link_active = 1'b0;
        start_frame(10);
        repeat (4) @(negedge clk);
        check("R2 link inactive busy", int'(busy), 0);
        check("R2 link inactive no write", nwr, 0);
        link_active = 1'b1;
        start_frame(0);
        repeat (4) @(negedge clk);
        check("R2 zero length busy", int'(busy), 0);
        check("R2 zero length no write", nwr, 0);
    endtask

    task automatic t_idle_ignore();
        clear_log();
        pulse_pool();
        @(negedge clk); underrun = 1'b1; @(negedge clk); underrun = 1'b0;
        @(negedge clk); msg_repeat = 1'b1; @(negedge clk); msg_repeat = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 idle no write", nwr, 0);
        check("R9 idle no confirm", nconf, 0);
        check("R9 idle busy", int'(busy), 0);
        run_clean(3, "R9 after idle events");
    endtask

    task automatic t_refuse();
        clear_log();
        start_frame(40);
        start_frame(3);
        wait_cmds(1, "R10");
        check("R10 first chunk size", log_cpos[0], 32);
        pulse_pool();
        wait_cmds(2, "R10");
        check("R10 final chunk kept length", log_cpos[1], 40);
        check("R10 final command", log_cmd[1], 8'h0A);
        pulse_pool();
        @(negedge clk);
        check("R10 confirm once", nconf, 1);
    endtask

    task automatic t_underrun_rewind();
        clear_log();
        start_frame(70);
        wait_cmds(1, "R8u"); pulse_pool();
        wait_cmds(2, "R8u");
        @(negedge clk); underrun = 1'b1; @(negedge clk); underrun = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 rewind alone writes nothing", nwr, 64);
        pulse_pool();
        wait_cmds(3, "R8u");
        check("R8 resend restart address", log_addr[64], 0);
        check("R8 resend chunk full", log_cpos[2], 96);
        check("R8 resend command fill only", log_cmd[2], 8'h08);
        pulse_pool(); wait_cmds(4, "R8u");
        pulse_pool(); wait_cmds(5, "R8u");
        check("R8 final command after rewind", log_cmd[4], 8'h0A);
        check_bytes("R8 resent", 64, 70, 0);
        pulse_pool();
        @(negedge clk);
        check("R8 confirm after full resend", nconf, 1);
    endtask

    task automatic t_repeat_priority();
        clear_log();
        start_frame(5);
        wait_cmds(1, "R8r");
        @(negedge clk); msg_repeat = 1'b1; pool_ready = 1'b1;
        @(negedge clk); msg_repeat = 1'b0; pool_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 repeat beats pool-ready: no write", nwr, 5);
        check("R8 repeat beats pool-ready: no confirm", nconf, 0);
        check("R8 still busy", int'(busy), 1);
        pulse_pool();
        wait_cmds(2, "R8r");
        check_bytes("R8 repeat", 5, 5, 0);
        check("R8 repeat final command", log_cmd[1], 8'h0A);
        pulse_pool();
        @(negedge clk);
        check("R8 repeat confirm", nconf, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_chunk_now();
        t_discard();
        run_clean(70, "R4 R5 R6 len70");
        run_clean(32, "R4 R5 len32");
        run_clean(33, "R4 R5 R6 len33");
        t_idle_ignore();
        t_refuse();
        t_underrun_rewind();
        t_repeat_priority();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule